// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block sits between the event sources of one serial channel and the host-visible identification register. It gathers seven interrupt sources, masks each with its enable bit, and reports the most urgent enabled one as a 6-bit identification code. It also drives a single active-high interrupt line, which the output-gate control bit qualifies. Some sources are levels that the neighbouring logic owns, such as the receive error flag, the receive trigger and the modem deltas. The others are single-cycle events that the block records in a sticky bit until that source's own clear action occurs.

A read of the identification register is a strobe that stays high for one or more cycles. For the whole strobe, the reported code is held at the value it had in the cycle before the strobe began. Sources that are cleared by that read are cleared in the first cycle of the strobe. A source that becomes pending during the read therefore appears on the next read, not on the one in progress.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_o` is 6'b000001 and `int_o` is 0.
- R2: Enabled pending sources are ranked from most to least urgent, with these codes: line status 6'b000110, receive timeout 6'b001100, receive data 6'b000100, transmit space 6'b000010, modem change 6'b000000, Xoff/special character 6'b010000, flow-control line change 6'b100000. With nothing pending the code is 6'b000001.
- R3: The line-status source is pending exactly while `rx_err_any_i` is 1 and `ier_i[2]` is 1. It drops as soon as the flag falls.
- R4: A one-cycle `rx_timeout_i` pulse sets a sticky timeout source. A `rd_rhr_i` strobe clears it. When receive data is also pending, the timeout code is reported in its place.
- R5: The receive-data source is pending while `rx_at_trig_i` is 1. `ier_i[0]` enables both receive data and receive timeout.
- R6: A 0-to-1 transition of `tx_below_trig_i` sets the sticky transmit-space source, which `ier_i[1]` enables. A `wr_thr_i` strobe clears it. An identification read also clears it, but only if that read reported 6'b000010. A read that reported another code leaves it pending.
- R7: The modem-change source is pending while any bit of `msr_delta_i` is 1, and `ier_i[3]` enables it.
- R8: `xoff_det_i` sets a sticky Xoff bit and `xon_det_i` clears it. `special_det_i` sets a sticky special-character bit. An identification read clears the special-character bit only if that read reported 6'b010000. An Xon clears only the Xoff bit. Either bit raises code 6'b010000, and `ier_i[5]` enables both.
- R9: `flow_chg_i` sets a sticky flow-change bit. `ier_i[6]` or `ier_i[7]` enables it. An identification read that reported 6'b100000 clears it.
- R10: `int_o` is 1 exactly when `out_gate_i` is 1 and at least one enabled source is pending. A disabled source still records its event and is reported once it is enabled.
- R11: While `rd_iir_i` stays high, `iir_o` holds the code from the cycle before the strobe rose. Sources set during the strobe show on `iir_o` once the strobe falls.
- R12: If a sticky source is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 8 | Interrupt enable register |
| out_gate_i | input | 1 | Output gate for the interrupt line |
| rx_err_any_i | input | 1 | Some character in the receive FIFO carries an error |
| rx_timeout_i | input | 1 | Receive timeout event (one cycle) |
| rx_at_trig_i | input | 1 | Receive level at or above trigger |
| tx_below_trig_i | input | 1 | Transmit level below trigger |
| msr_delta_i | input | 4 | Modem status change bits |
| xoff_det_i | input | 1 | Xoff detected (one cycle) |
| xon_det_i | input | 1 | Xon detected (one cycle) |
| special_det_i | input | 1 | Special character detected (one cycle) |
| flow_chg_i | input | 1 | RTS/CTS went inactive (one cycle) |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_rhr_i | input | 1 | Receive holding register read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| iir_o | output | 6 | Identification code |
| int_o | output | 1 | Interrupt line, active high |

## Verification
The sticky-source assertions assume that the event inputs and the access strobes are synchronous to the clock and stable across each edge. Under that assumption, every set or clear seen at an edge has its effect one cycle later. The freeze assertion assumes that a read is a single continuous high interval of `rd_iir_i`. The stimulus meets these assumptions by changing every input shortly after a rising edge and holding it for at least one full cycle. Each event is a single one-cycle pulse, and each read is a contiguous strobe.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IIR_W   = 6;
  localparam int unsigned NSRC    = 7;
  localparam int unsigned NSTICKY = 5;

  // source rank, index 0 most urgent
  localparam int unsigned S_LS  = 0;
  localparam int unsigned S_TO  = 1;
  localparam int unsigned S_RXD = 2;
  localparam int unsigned S_THR = 3;
  localparam int unsigned S_MS  = 4;
  localparam int unsigned S_XF  = 5;
  localparam int unsigned S_FC  = 6;

  // sticky slots
  localparam int unsigned K_TO  = 0;
  localparam int unsigned K_THR = 1;
  localparam int unsigned K_XOF = 2;
  localparam int unsigned K_SPC = 3;
  localparam int unsigned K_FC  = 4;

  localparam logic [IIR_W-1:0] IIR_NONE = 6'b000001;
  localparam logic [IIR_W-1:0] IIR_LS   = 6'b000110;
  localparam logic [IIR_W-1:0] IIR_TO   = 6'b001100;
  localparam logic [IIR_W-1:0] IIR_RXD  = 6'b000100;
  localparam logic [IIR_W-1:0] IIR_THR  = 6'b000010;
  localparam logic [IIR_W-1:0] IIR_MS   = 6'b000000;
  localparam logic [IIR_W-1:0] IIR_XF   = 6'b010000;
  localparam logic [IIR_W-1:0] IIR_FC   = 6'b100000;

  function automatic logic [IIR_W-1:0] src_code(int unsigned idx);
    case (idx)
      S_LS:    return IIR_LS;
      S_TO:    return IIR_TO;
      S_RXD:   return IIR_RXD;
      S_THR:   return IIR_THR;
      S_MS:    return IIR_MS;
      S_XF:    return IIR_XF;
      default: return IIR_FC;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;   // set wins over clear
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r12_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int unsigned N = 7,
  parameter int unsigned W = 6,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][W-1:0] code_tab_i,
  output logic [W-1:0]        code_o
);
  logic [N-1:0] above;
  logic [N-1:0] grant;

  assign above[0] = 1'b0;
  assign grant[0] = req_i[0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign above[i] = above[i-1] | req_i[i-1];
    assign grant[i] = req_i[i] & ~above[i];
  end

  always_comb begin
    code_o = (|req_i) ? '0 : IDLE;
    for (int i = 0; i < N; i++)
      if (grant[i]) code_o = code_o | code_tab_i[i];
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned IER_W = 8,
  parameter int unsigned MSR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IER_W-1:0] ier_i,
  input  logic             out_gate_i,
  input  logic             rx_err_any_i,
  input  logic             rx_timeout_i,
  input  logic             rx_at_trig_i,
  input  logic             tx_below_trig_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             xoff_det_i,
  input  logic             xon_det_i,
  input  logic             special_det_i,
  input  logic             flow_chg_i,
  input  logic             rd_iir_i,
  input  logic             rd_rhr_i,
  input  logic             wr_thr_i,
  output logic [IIR_W-1:0] iir_o,
  output logic             int_o
);
  logic                  tx_lvl_q, rd_q;
  logic [IIR_W-1:0]      hold_q, code_now;
  logic                  rd_start;
  logic [NSTICKY-1:0]    st_set, st_clr, st_q;
  logic [NSRC-1:0]       raw, en, req;
  logic [NSRC-1:0][IIR_W-1:0] code_tab;
  logic                  unused_ier;

  assign unused_ier = ^ier_i;
  assign rd_start   = rd_iir_i & ~rd_q;

  always_comb begin
    st_set        = '0;
    st_clr        = '0;
    st_set[K_TO]  = rx_timeout_i;
    st_clr[K_TO]  = rd_rhr_i;
    st_set[K_THR] = tx_below_trig_i & ~tx_lvl_q;
    st_clr[K_THR] = wr_thr_i | (rd_start && hold_q == IIR_THR);
    st_set[K_XOF] = xoff_det_i;
    st_clr[K_XOF] = xon_det_i;
    st_set[K_SPC] = special_det_i;
    st_clr[K_SPC] = rd_start && hold_q == IIR_XF;
    st_set[K_FC]  = flow_chg_i;
    st_clr[K_FC]  = rd_start && hold_q == IIR_FC;
  end

  for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
    uart_irq_sticky u_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (st_set[k]),
      .clr_i  (st_clr[k]),
      .q_o    (st_q[k])
    );
  end

  always_comb begin
    raw[S_LS]  = rx_err_any_i;
    raw[S_TO]  = st_q[K_TO];
    raw[S_RXD] = rx_at_trig_i;
    raw[S_THR] = st_q[K_THR];
    raw[S_MS]  = |msr_delta_i;
    raw[S_XF]  = st_q[K_XOF] | st_q[K_SPC];
    raw[S_FC]  = st_q[K_FC];
    en[S_LS]   = ier_i[2];
    en[S_TO]   = ier_i[0];
    en[S_RXD]  = ier_i[0];
    en[S_THR]  = ier_i[1];
    en[S_MS]   = ier_i[3];
    en[S_XF]   = ier_i[5];
    en[S_FC]   = ier_i[6] | ier_i[7];
  end

  assign req = raw & en;

  for (genvar s = 0; s < NSRC; s++) begin : g_tab
    assign code_tab[s] = src_code(s);
  end

  uart_irq_prio #(.N(NSRC), .W(IIR_W), .IDLE(IIR_NONE)) u_prio (
    .req_i      (req),
    .code_tab_i (code_tab),
    .code_o     (code_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_lvl_q <= 1'b0;
      rd_q     <= 1'b0;
      hold_q   <= IIR_NONE;
    end else begin
      tx_lvl_q <= tx_below_trig_i;
      rd_q     <= rd_iir_i;
      if (!rd_iir_i) hold_q <= code_now;
    end
  end

  assign iir_o = rd_iir_i ? hold_q : code_now;
  assign int_o = out_gate_i & (|req);

  a_r10_int_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && !rd_iir_i) |-> !iir_o[0]);
  a_r11_frozen_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_iir_i && $past(rd_iir_i)) |-> $stable(iir_o));
  a_r3_line_status_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_any_i && ier_i[2] && !rd_iir_i) |-> iir_o == IIR_LS);
  a_r1_idle_no_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_iir_i && iir_o == IIR_NONE) |-> !int_o);
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ier = '0;
  logic gate = 1'b0, err = 1'b0, tmo = 1'b0, trig = 1'b0, txb = 1'b0;
  logic [3:0] msr = '0;
  logic xoff = 1'b0, xon = 1'b0, spc = 1'b0, fchg = 1'b0;
  logic rd_iir = 1'b0, rd_rhr = 1'b0, wr_thr = 1'b0;
  logic [5:0] iir;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .out_gate_i(gate),
    .rx_err_any_i(err), .rx_timeout_i(tmo), .rx_at_trig_i(trig),
    .tx_below_trig_i(txb), .msr_delta_i(msr), .xoff_det_i(xoff),
    .xon_det_i(xon), .special_det_i(spc), .flow_chg_i(fchg),
    .rd_iir_i(rd_iir), .rd_rhr_i(rd_rhr), .wr_thr_i(wr_thr),
    .iir_o(iir), .int_o(irq)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic pulse(int which);
    case (which)
      0: tmo = 1'b1;  1: xoff = 1'b1; 2: xon = 1'b1; 3: spc = 1'b1;
      4: fchg = 1'b1; 5: rd_rhr = 1'b1; default: wr_thr = 1'b1;
    endcase
    tick();
    {tmo, xoff, xon, spc, fchg, rd_rhr, wr_thr} = '0;
    #1;
  endtask

  task automatic read_iir(output logic [5:0] got);
    tick();
    rd_iir = 1'b1; #1;
    got = iir;
    tick();
    rd_iir = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R1 iir", iir, 6'b000001);
    chk("R1 int", {5'b0, irq}, 6'd0);
  endtask

  task automatic t_line();
    gate = 1; ier = 8'h04; err = 1; #1;
    chk("R3 line set", iir, 6'b000110);
    chk("R10 int line", {5'b0, irq}, 6'd1);
    err = 0; #1;
    chk("R3 line drop", iir, 6'b000001);
  endtask

  task automatic t_rx();
    ier = 8'h01; trig = 1; #1;
    chk("R5 rx data", iir, 6'b000100);
    pulse(0);
    chk("R4 timeout over data", iir, 6'b001100);
    pulse(5);
    chk("R4 timeout cleared", iir, 6'b000100);
    trig = 0; #1;
    chk("R5 rx data drop", iir, 6'b000001);
  endtask

  task automatic t_thr();
    logic [5:0] g;
    ier = 8'h02; txb = 1; tick();
    chk("R6 thr set", iir, 6'b000010);
    read_iir(g);
    chk("R6 read code", g, 6'b000010);
    chk("R6 read clears", iir, 6'b000001);
    txb = 0; tick(); txb = 1; tick();
    chk("R6 thr reset", iir, 6'b000010);
    pulse(6);
    chk("R6 write clears", iir, 6'b000001);
    txb = 0; tick(); txb = 1; tick();
    ier = 8'h03; trig = 1; #1;
    read_iir(g);
    chk("R6 other code read", g, 6'b000100);
    trig = 0; #1;
    chk("R6 thr kept", iir, 6'b000010);
    pulse(6); txb = 0; tick();
  endtask

  task automatic t_modem();
    ier = 8'h08; msr = 4'b0010; #1;
    chk("R7 modem", iir, 6'b000000);
    chk("R7 int", {5'b0, irq}, 6'd1);
    msr = 0; #1;
    chk("R7 modem drop", iir, 6'b000001);
  endtask

  task automatic t_xoff();
    logic [5:0] g;
    ier = 8'h20; pulse(1);
    chk("R8 xoff", iir, 6'b010000);
    read_iir(g);
    chk("R8 xoff kept after read", iir, 6'b010000);
    pulse(2);
    chk("R8 xon clears", iir, 6'b000001);
    pulse(3);
    chk("R8 special", iir, 6'b010000);
    pulse(2);
    chk("R8 xon ignores special", iir, 6'b010000);
    read_iir(g);
    chk("R8 read clears special", iir, 6'b000001);
  endtask

  task automatic t_flow();
    logic [5:0] g;
    ier = 8'h80; pulse(4);
    chk("R9 flow", iir, 6'b100000);
    read_iir(g);
    chk("R9 read code", g, 6'b100000);
    chk("R9 cleared", iir, 6'b000001);
  endtask

  task automatic t_mask();
    logic [5:0] g;
    ier = 8'h00; pulse(4);
    chk("R10 masked iir", iir, 6'b000001);
    chk("R10 masked int", {5'b0, irq}, 6'd0);
    ier = 8'h40; #1;
    chk("R10 unmasked", iir, 6'b100000);
    chk("R10 int on", {5'b0, irq}, 6'd1);
    gate = 0; #1;
    chk("R10 gate off", {5'b0, irq}, 6'd0);
    read_iir(g);
    gate = 1; #1;
  endtask

  task automatic t_priority();
    ier = 8'hff; err = 1; trig = 1; msr = 4'b1000;
    pulse(0); pulse(1); pulse(4);
    txb = 0; tick(); txb = 1; tick();
    chk("R2 line first", iir, 6'b000110);
    err = 0; #1;
    chk("R2 timeout", iir, 6'b001100);
    pulse(5);
    chk("R2 rx data", iir, 6'b000100);
    trig = 0; #1;
    chk("R2 thr", iir, 6'b000010);
    pulse(6);
    chk("R2 modem", iir, 6'b000000);
    msr = 0; #1;
    chk("R2 xoff", iir, 6'b010000);
    pulse(2);
    chk("R2 flow", iir, 6'b100000);
    begin logic [5:0] g; read_iir(g); end
    chk("R2 none", iir, 6'b000001);
    txb = 0; tick();
  endtask

  task automatic t_freeze();
    logic [5:0] g;
    ier = 8'hff; tick();
    rd_iir = 1; #1;
    chk("R11 read start", iir, 6'b000001);
    fchg = 1; tick(); fchg = 0; #1;
    chk("R11 frozen 1", iir, 6'b000001);
    tick();
    chk("R11 frozen 2", iir, 6'b000001);
    rd_iir = 0; #1;
    chk("R11 after read", iir, 6'b100000);
    read_iir(g);
    chk("R11 next read", g, 6'b100000);
  endtask

  task automatic t_setwins();
    ier = 8'h02; txb = 0; tick();
    txb = 1; wr_thr = 1; tick(); wr_thr = 0; #1;
    chk("R12 set beats clear", iir, 6'b000010);
    pulse(6);
    chk("R12 later clear", iir, 6'b000001);
    txb = 0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #10; tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_line();
    t_rx();
    t_thr();
    t_modem();
    t_xoff();
    t_flow();
    t_mask();
    t_priority();
    t_freeze();
    t_setwins();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule